// File: doc/BRIEF.md
# Multi-channel down-counting timer bank

The block holds six independent 32-bit down-counters behind one word-addressed register bus. Each channel has a control word, a reload value and a live count. A running channel decrements on count events. A count event is derived from one of three tick sources, followed by a power-of-two prescaler. When the count reaches zero, the channel either reloads and keeps going, reloads and parks, or stops at zero. In every case it raises a pending flag.

The pending flags share an enable mask, and their enabled OR drives one registered interrupt line. Software can clear a flag by writing a one to it. Software can also rewrite the live count or the reload value at any time. The whole block runs on one clock. The two tick inputs are single-cycle enables from clock sources generated elsewhere.

Top module: `timer_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero, no channel runs and `irq` is low.
- R2: The register map is fixed. Word 0x00 is the interrupt enable mask and word 0x04 is the pending flags, with bit n belonging to channel n. Channel n uses 0x10+0x10·n for control, +0x04 for reload and +0x08 for the live count. Address bits 1:0 are ignored. `bus_rdata` presents the register addressed on the previous clock edge, as it stood before that edge.
- R3: In the control word, bit 0 is run and bit 1 is reload. Bits 3:2 pick the tick source: 00 selects `tick_slow`, 01 selects `tick_osc`, and 10 or 11 select every clock. Bits 6:4 are the prescaler exponent P, and bit 7 is one-shot. Control reads back all eight bits.
- R4: A running channel takes a count event on every 2^P-th selected tick since run was last set. The tick tally starts from zero while the channel is stopped. Each event lowers the count by one.
- R5: With run clear, the count holds its value. A read of the live count always returns the present value.
- R6: A count event that finds the count at 0 or 1 is an expiry. The channel's pending bit is set on the same edge that the expiry updates the count.
- R7: On expiry with reload=1 and one-shot=0, the count is loaded from the reload register and run stays set.
- R8: On expiry with reload=0, the count becomes 0 and run is cleared.
- R9: On expiry with reload=1 and one-shot=1, the count is loaded from the reload register and run is cleared.
- R10: A write to the live count replaces it and takes precedence over a count event on the same edge. A write to the reload register leaves the live count untouched.
- R11: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. An expiry on the same edge keeps the bit set.
- R12: `irq` goes high one clock after any pending bit and its enable bit are both set, and it drops one clock after no such pair remains.
- R13: Writes to unmapped words, including 0x08, 0x0C, and channel slots beyond the last channel, have no effect. Reads of those words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the word addressed on the prior edge |
| tick_slow | input | 1 | Single-cycle enable of the slow tick source |
| tick_osc | input | 1 | Single-cycle enable of the oscillator tick source |
| irq | output | 1 | Registered interrupt: OR of enabled pending flags |

## Verification
The hardest situation to reach from the ports is a count event that lands on the same edge as a bus write to that channel, or an expiry that coincides with a write-one-clear of its own pending bit. The precedence rules then decide the outcome. The stimulus keeps channels running on the every-clock source with short reloads while it performs status clears and live-count reads, so these collisions occur repeatedly. A behavioural model checks every cycle. Prescaler and source selection are checked by taking two reads of a running count a known number of cycles apart and comparing the difference with the tick pattern the bench drives.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTRL_W = 8;
  localparam int PSC_W  = 3;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_SYSA = 2'b10,
    SRC_SYSB = 2'b11
  } tsrc_e;

  // bit 0 run, bit 1 reload, 3:2 source, 6:4 prescale exponent, 7 one-shot
  typedef struct packed {
    logic              one_shot;
    logic [PSC_W-1:0]  psc;
    tsrc_e             src;
    logic              reload;
    logic              run;
  } tctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RELD = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  tsrc_e            src,
  input  logic [PSC_W-1:0] psc,
  input  logic             tick_slow,
  input  logic             tick_osc,
  output logic             step
);
  localparam int TALLY_W = (1 << PSC_W) - 1;

  logic               tick;
  logic [TALLY_W-1:0] tally;
  logic [TALLY_W-1:0] mask;

  always_comb begin
    case (src)
      SRC_SLOW: tick = tick_slow;
      SRC_OSC:  tick = tick_osc;
      default:  tick = 1'b1;
    endcase
  end

  assign mask = (TALLY_W'(1) << psc) - TALLY_W'(1);
  assign step = run && tick && ((tally & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) tally <= '0;
    else if (tick)   tally <= tally + TALLY_W'(1);
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_slow,
  input  logic              tick_osc,
  input  logic              wr_ctrl,
  input  logic              wr_reld,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output tctrl_t            ctrl_q,
  output logic [DATA_W-1:0] reld_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              step,
  output logic              expire
);
  logic keep_running;

  timer_prescale u_psc (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .src       (ctrl_q.src),
    .psc       (ctrl_q.psc),
    .tick_slow (tick_slow),
    .tick_osc  (tick_osc),
    .step      (step)
  );

  assign expire       = step && (cnt_q <= DATA_W'(1));
  assign keep_running = ctrl_q.reload && !ctrl_q.one_shot;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      reld_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl)                     ctrl_q     <= tctrl_t'(wdata[CTRL_W-1:0]);
      else if (expire && !keep_running) ctrl_q.run <= 1'b0;

      if (wr_reld) reld_q <= wdata;

      if (wr_cnt)      cnt_q <= wdata;
      else if (expire) cnt_q <= ctrl_q.reload ? reld_q : '0;
      else if (step)   cnt_q <= cnt_q - DATA_W'(1);
    end
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_osc,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int SLOT_W = ADDR_W - 4;

  logic [NUM_CH-1:0]             irq_en, pend, expire, run_vec, step_vec;
  logic [NUM_CH-1:0]             clr_mask;
  tctrl_t [NUM_CH-1:0]           ctrl_vec;
  logic [NUM_CH-1:0][DATA_W-1:0] reld_vec, cnt_vec;
  logic [DATA_W-1:0]             rd_next;
  logic                          hit_en, hit_sts;

  assign hit_en   = bus_addr[ADDR_W-1:2] == WORD_W'(0);
  assign hit_sts  = bus_addr[ADDR_W-1:2] == WORD_W'(1);
  assign clr_mask = (bus_we && hit_sts) ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic slot_hit;
    assign slot_hit = bus_we && (bus_addr[ADDR_W-1:4] == SLOT_W'(i + 1));

    timer_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick_slow (tick_slow),
      .tick_osc  (tick_osc),
      .wr_ctrl   (slot_hit && bus_addr[3:2] == SEL_CTRL),
      .wr_reld   (slot_hit && bus_addr[3:2] == SEL_RELD),
      .wr_cnt    (slot_hit && bus_addr[3:2] == SEL_CNT),
      .wdata     (bus_wdata),
      .ctrl_q    (ctrl_vec[i]),
      .reld_q    (reld_vec[i]),
      .cnt_q     (cnt_vec[i]),
      .step      (step_vec[i]),
      .expire    (expire[i])
    );
    assign run_vec[i] = ctrl_vec[i].run;
  end

  always_comb begin
    rd_next = '0;
    if (hit_en)  rd_next[NUM_CH-1:0] = irq_en;
    if (hit_sts) rd_next[NUM_CH-1:0] = pend;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr[ADDR_W-1:4] == SLOT_W'(i + 1)) begin
        case (bus_addr[3:2])
          SEL_CTRL: rd_next = {{(DATA_W-CTRL_W){1'b0}}, ctrl_vec[i]};
          SEL_RELD: rd_next = reld_vec[i];
          SEL_CNT:  rd_next = cnt_vec[i];
          default:  rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en    <= '0;
      pend      <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && hit_en) irq_en <= bus_wdata[NUM_CH-1:0];
      pend      <= (pend & ~clr_mask) | expire;
      irq       <= |(pend & irq_en);
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_we,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic                          irq,
  input logic [NUM_CH-1:0]             pend,
  input logic [NUM_CH-1:0]             irq_en,
  input logic [NUM_CH-1:0]             run_vec,
  input logic [NUM_CH-1:0]             step_vec,
  input logic [NUM_CH-1:0]             expire,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_vec
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (irq == 1'b0 && pend == '0)); // R1

  AST_EXPIRE_PEND: assert property (@(posedge clk) disable iff (rst)
    (expire != '0) |=> ((pend & $past(expire)) == $past(expire))); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1) && expire == '0)
    |=> ((pend & $past(bus_wdata[NUM_CH-1:0])) == '0)); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((pend & irq_en) != '0)); // R12

  AST_EXPIRE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (expire & ~run_vec) == '0); // R4

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!run_vec[i] && !bus_we) |=> $stable(cnt_vec[i])); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (run_vec[i] && !step_vec[i] && !bus_we) |=> $stable(cnt_vec[i])); // R4

    AST_STEP_DECR: assert property (@(posedge clk) disable iff (rst)
      (step_vec[i] && cnt_vec[i] > DATA_W'(1) && !bus_we)
      |=> (cnt_vec[i] == $past(cnt_vec[i]) - DATA_W'(1))); // R4
  end
endmodule

bind timer_bank timer_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .pend      (pend),
  .irq_en    (irq_en),
  .run_vec   (run_vec),
  .step_vec  (step_vec),
  .expire    (expire),
  .cnt_vec   (cnt_vec)
);

// File: tb/test_timer_bank.sv
module test_timer_bank;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_osc = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit started  = 0;

  always #4 clk = ~clk;

  timer_bank i_timer_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_osc(tick_osc), .irq(irq)
  );

  // behavioural reference state
  bit [7:0]    m_ctrl [NCH];
  bit [31:0]   m_reld [NCH];
  bit [31:0]   m_cnt  [NCH];
  int          m_tally[NCH];
  bit [NCH-1:0] m_en, m_pend;
  bit [31:0]   m_rdata;
  bit          m_irq;
  string       m_tag = "R1";

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model_read(input bit [7:0] a, output bit [31:0] v, output string tg);
    int w = a & 8'hFC;
    v = '0; tg = "R13";
    if (w == 0)      begin v = 32'(m_en);   tg = "R2";  end
    else if (w == 4) begin v = 32'(m_pend); tg = "R6";  end
    else if (w >= 16 && (w / 16 - 1) < NCH) begin
      int ch = w / 16 - 1;
      case ((w % 16) / 4)
        0: begin v = 32'(m_ctrl[ch]); tg = "R3"; end
        1: begin v = m_reld[ch];      tg = "R10"; end
        2: begin v = m_cnt[ch];       tg = "R4"; end
        default: begin v = '0;        tg = "R13"; end
      endcase
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = '0; m_reld[c] = '0; m_cnt[c] = '0; m_tally[c] = 0;
      end
      m_en = '0; m_pend = '0; m_rdata = '0; m_irq = 0; m_tag = "R1";
    end else begin
      bit [31:0] rv; string tg; bit [NCH-1:0] ex_v, clr; bit irq_n;
      int w;
      w = bus_addr & 8'hFC;
      model_read(bus_addr, rv, tg);
      irq_n = |(m_pend & m_en);
      ex_v = '0;
      clr = (bus_we && w == 4) ? bus_wdata[NCH-1:0] : '0;
      for (int c = 0; c < NCH; c++) begin
        bit tk, st, ex, ar, os, run;
        int div, base;
        run  = m_ctrl[c][0]; ar = m_ctrl[c][1]; os = m_ctrl[c][7];
        tk   = m_ctrl[c][3] ? 1'b1 : (m_ctrl[c][2] ? tick_osc : tick_slow);
        div  = 1 << m_ctrl[c][6:4];
        st   = run && tk && ((m_tally[c] % div) == div - 1);
        ex   = st && (m_cnt[c] <= 1);
        base = 16 * (c + 1);
        ex_v[c] = ex;
        m_tally[c] = run ? (tk ? m_tally[c] + 1 : m_tally[c]) : 0;
        if (bus_we && w == base + 8) m_cnt[c] = bus_wdata;
        else if (ex) m_cnt[c] = ar ? m_reld[c] : 0;
        else if (st) m_cnt[c] = m_cnt[c] - 1;
        if (bus_we && w == base + 4) m_reld[c] = bus_wdata;
        if (bus_we && w == base) m_ctrl[c] = bus_wdata[7:0];
        else if (ex && !(ar && !os)) m_ctrl[c][0] = 1'b0;
      end
      m_pend = (m_pend & ~clr) | ex_v;
      if (bus_we && w == 0) m_en = bus_wdata[NCH-1:0];
      m_rdata = rv; m_irq = irq_n; m_tag = tg;
      started = 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(bus_rdata == m_rdata, m_tag, bus_rdata, m_rdata);
      check(irq == m_irq, "R12", irq, m_irq);
    end
  end

  // tick sources: slow every 5 clocks, oscillator every 2
  always @(negedge clk) begin
    cyc++;
    tick_slow = (cyc % 5 == 0);
    tick_osc  = (cyc % 2 == 0);
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, output bit [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit [31:0] v, v2;
    idle(3);
    rst = 1'b0;
    // R1: reset state
    rd(8'h00, v); check(v == 0, "R1", v, 0);
    rd(8'h04, v); check(v == 0, "R1", v, 0);
    rd(8'h10, v); check(v == 0, "R1", v, 0);
    rd(8'h18, v); check(v == 0, "R1", v, 0);
    check(irq == 0, "R1", irq, 0);

    // R10 / R2: reload write leaves count alone; map offsets
    wr(8'h28, 3);
    wr(8'h24, 99);
    rd(8'h28, v); check(v == 3, "R10", v, 3);
    rd(8'h25, v); check(v == 99, "R2", v, 99);

    // R8: reload off -> stop at zero, run cleared
    wr(8'h38, 4);
    wr(8'h30, 32'h09);
    idle(20);
    rd(8'h38, v); check(v == 0, "R8", v, 0);
    rd(8'h30, v); check(v == 32'h08, "R8", v, 32'h08);

    // R9: reload + one-shot -> reload then park
    wr(8'h44, 7);
    wr(8'h48, 2);
    wr(8'h40, 32'h8B);
    idle(20);
    rd(8'h48, v); check(v == 7, "R9", v, 7);
    rd(8'h40, v); check(v == 32'h8A, "R9", v, 32'h8A);

    // R7: continuous reload keeps running
    wr(8'h14, 5);
    wr(8'h18, 5);
    wr(8'h10, 32'h0B);
    idle(30);
    rd(8'h10, v); check(v == 32'h0B, "R7", v, 32'h0B);
    rd(8'h04, v); check(v[0] == 1'b1, "R6", v, 32'h0D);
    rd(8'h14, v); check(v == 5, "R2", v, 5);
    // W1C while running on ch0 to collide with expiries
    repeat (6) begin
      wr(8'h04, 32'h01);
      idle(1);
    end

    // R5: stop freezes the count
    wr(8'h10, 32'h0A);
    rd(8'h18, v);
    idle(10);
    rd(8'h18, v2); check(v == v2, "R5", v2, v);
    check(v <= 5, "R5", v, 5);

    // R11: write-one-to-clear, zero leaves bits
    wr(8'h04, 32'h01);
    rd(8'h04, v); check(v == 32'h0C, "R11", v, 32'h0C);
    wr(8'h04, 32'h00);
    rd(8'h04, v); check(v == 32'h0C, "R11", v, 32'h0C);

    // R12: interrupt follows enabled pending
    wr(8'h00, 32'h04);
    idle(2);
    check(irq == 1'b1, "R12", irq, 1);
    wr(8'h00, 32'h01);
    idle(2);
    check(irq == 1'b0, "R12", irq, 0);

    // R4: prescaler exponent 2 -> one event per 4 ticks
    wr(8'h58, 1000);
    wr(8'h50, 32'h29);
    idle(3);
    rd(8'h58, v);
    idle(39);
    rd(8'h58, v2); check(v - v2 == 10, "R4", v - v2, 10);

    // R3: slow source, then oscillator source
    wr(8'h68, 1000);
    wr(8'h60, 32'h01);
    idle(5);
    rd(8'h68, v);
    idle(49);
    rd(8'h68, v2); check(v - v2 == 10, "R3", v - v2, 10);
    wr(8'h60, 32'h05);
    idle(5);
    rd(8'h68, v);
    idle(49);
    rd(8'h68, v2); check(v - v2 == 25, "R3", v - v2, 25);

    // R10: count write wins over running count
    wr(8'h58, 500);
    rd(8'h58, v); check(v == 500 || v == 499, "R10", v, 500);

    // R13: unmapped words
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); check(v == 0, "R13", v, 0);
    wr(8'h70, 32'h0B);
    rd(8'h70, v); check(v == 0, "R13", v, 0);
    rd(8'h08, v); check(v == 0, "R13", v, 0);
    rd(8'h04, v); check(v[5:4] == 2'b00, "R13", v, 0);

    idle(5);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule